// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block sits on the controller side of a single-data-rate SDRAM and takes the memory from power-on to a programmed, idle state. After reset is released it drives NOP for a configurable pause, with the clock-enable and data-mask outputs held high. It then issues a precharge of all banks, a mode register set that carries the caller's mode word on the address bus, and a burst of auto-refresh commands. Each command is followed by the gap the device needs before the next one.

A parameter selects whether the refresh burst runs before or after the mode register set. When the final gap has elapsed, the block raises its done flag and then drives NOP indefinitely. The memory controller can take over the command pins from that point. Every output is registered. All command gaps are counted in clock cycles and must be at least two.

Top module: `sdram_init_seq`

## Requirements
- R1: While rst_ni is low the outputs hold the NOP code (cs_no=0, ras_no=1, cas_no=1, we_no=1), cke_o=1, dqm_o=1, addr_o=0 and init_done_o=0.
- R2: For PAUSE_CYCLES clock cycles from reset release, counting the cycle in which reset is released, the pins carry NOP, addr_o is zero, and cke_o and dqm_o stay high.
- R3: The first command after the pause is precharge-all, coded cs_no=0, ras_no=0, cas_no=1, we_no=0, with addr_o holding only bit AP_BIT (default 10) set.
- R4: The mode register set is coded with cs_no, ras_no, cas_no and we_no all 0, and addr_o equals mode_i.
- R5: Exactly REFRESH_COUNT auto-refresh commands are issued. Each is coded cs_no=0, ras_no=0, cas_no=0, we_no=1 with addr_o zero, and consecutive refreshes are T_RFC cycles apart.
- R6: The command after a precharge comes T_RP cycles after it, and the command after a mode set comes T_MRD cycles after it. Every cycle in between is NOP with addr_o zero, so the cycle after a mode set is always NOP.
- R7: With REFRESH_FIRST=1 the order is precharge, refreshes, mode set. With REFRESH_FIRST=0 the order is precharge, mode set, refreshes.
- R8: init_done_o rises exactly one gap (T_RFC or T_MRD, whichever belongs to the final command) after the last command. From that cycle dqm_o is low and cke_o stays high.
- R9: Once init_done_o is high it stays high until reset, and the pins stay at NOP with addr_o zero.
- R10: Asserting reset part-way through the sequence returns the block to the R1 state, and the next release restarts the sequence from the full pause.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| mode_i | input | ADDR_W | Mode word placed on the address bus during mode set |
| cke_o | output | 1 | Clock enable to the memory |
| dqm_o | output | 1 | Data mask, high until initialization is done |
| cs_no | output | 1 | Chip select, active low |
| ras_no | output | 1 | Row strobe, active low |
| cas_no | output | 1 | Column strobe, active low |
| we_no | output | 1 | Write enable, active low |
| addr_o | output | ADDR_W | Address bus |
| init_done_o | output | 1 | Initialization complete, sticky until reset |

## Verification
A gap counter that is off by one moves every later command by a cycle, and so does a wrong wait state. The per-cycle comparison reports this on the first command after the faulty wait. A refresh counter that ends early or late changes the number of refresh codes seen. The mode set then appears in the wrong place, or init_done_o rises too soon or too late, and the fault is visible within one T_RFC. A bad decode of the command or address shows in the cycle where that command is driven. Both refresh orders run side by side, so an error in the ordering branch shows at the end of the precharge gap.

// File: rtl/sdram_init_pkg.sv
package sdram_init_pkg;

  typedef enum logic [2:0] {
    ST_PAUSE,
    ST_PRECHG,
    ST_WAIT_RP,
    ST_REFRESH,
    ST_WAIT_RFC,
    ST_MODESET,
    ST_WAIT_MRD,
    ST_IDLE
  } init_state_e;

  typedef enum logic [1:0] {
    CMD_NOP,
    CMD_PRECHG,
    CMD_REFRESH,
    CMD_MODESET
  } init_cmd_e;

  typedef struct packed {
    logic cs_n;
    logic ras_n;
    logic cas_n;
    logic we_n;
  } cmd_pins_t;

  localparam cmd_pins_t PINS_NOP     = '{cs_n: 1'b0, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};
  localparam cmd_pins_t PINS_PRECHG  = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b1, we_n: 1'b0};
  localparam cmd_pins_t PINS_REFRESH = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b1};
  localparam cmd_pins_t PINS_MODESET = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b0};

  function automatic cmd_pins_t encode_cmd(init_cmd_e cmd);
    case (cmd)
      CMD_PRECHG:  return PINS_PRECHG;
      CMD_REFRESH: return PINS_REFRESH;
      CMD_MODESET: return PINS_MODESET;
      default:     return PINS_NOP;
    endcase
  endfunction

  function automatic init_cmd_e state_cmd(init_state_e st);
    case (st)
      ST_PRECHG:  return CMD_PRECHG;
      ST_REFRESH: return CMD_REFRESH;
      ST_MODESET: return CMD_MODESET;
      default:    return CMD_NOP;
    endcase
  endfunction

endpackage

// File: rtl/sdram_init_timer.sv
module sdram_init_timer #(
  parameter int CNT_W     = 16,
  parameter int RESET_VAL = 0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic             zero_o
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= CNT_W'(RESET_VAL);
    else if (load_i)        cnt_q <= load_val_i;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);

  // R6: a gap shrinks by exactly one per cycle until it expires
  a_r6_timer_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));

  a_r6_timer_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && zero_o) |=> zero_o);

endmodule

// File: rtl/sdram_init_ref_cnt.sv
module sdram_init_ref_cnt #(
  parameter int REFRESH_COUNT = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic inc_i,
  output logic all_done_o
);

  localparam int RC_W = $clog2(REFRESH_COUNT + 1);

  logic [RC_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (inc_i)  cnt_q <= cnt_q + 1'b1;
  end

  assign all_done_o = (cnt_q == RC_W'(REFRESH_COUNT));

  // R5: never more refreshes than configured
  a_r5_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    all_done_o |-> !inc_i);

endmodule

// File: rtl/sdram_init_cmd_enc.sv
module sdram_init_cmd_enc
  import sdram_init_pkg::*;
#(
  parameter int ADDR_W = 13,
  parameter int AP_BIT = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  init_cmd_e         cmd_i,
  input  logic              done_i,
  input  logic [ADDR_W-1:0] mode_i,
  output cmd_pins_t         pins_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              cke_o,
  output logic              dqm_o,
  output logic              done_o
);

  logic [ADDR_W-1:0] addr_d;

  always_comb begin
    addr_d = '0;
    case (cmd_i)
      CMD_PRECHG:  addr_d[AP_BIT] = 1'b1;
      CMD_MODESET: addr_d = mode_i;
      default:     addr_d = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pins_o <= PINS_NOP;
      addr_o <= '0;
      cke_o  <= 1'b1;
      dqm_o  <= 1'b1;
      done_o <= 1'b0;
    end else begin
      pins_o <= encode_cmd(cmd_i);
      addr_o <= addr_d;
      cke_o  <= 1'b1;
      dqm_o  <= !done_i;
      done_o <= done_i;
    end
  end

  // R3: precharge-all always carries the auto-precharge bit alone
  a_r3_prechg_addr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pins_o == PINS_PRECHG) |-> (addr_o == (ADDR_W'(1) << AP_BIT)));

  // R5: refresh carries a zero address
  a_r5_ref_addr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pins_o == PINS_REFRESH) |-> (addr_o == '0));

endmodule

// File: rtl/sdram_init_seq.sv
module sdram_init_seq
  import sdram_init_pkg::*;
#(
  parameter int ADDR_W        = 13,
  parameter int AP_BIT        = 10,
  parameter int PAUSE_CYCLES  = 20000,
  parameter int T_RP          = 3,
  parameter int T_RFC         = 9,
  parameter int T_MRD         = 2,
  parameter int REFRESH_COUNT = 8,
  parameter bit REFRESH_FIRST = 1'b0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] mode_i,
  output logic              cke_o,
  output logic              dqm_o,
  output logic              cs_no,
  output logic              ras_no,
  output logic              cas_no,
  output logic              we_no,
  output logic [ADDR_W-1:0] addr_o,
  output logic              init_done_o
);

  localparam int MAX_GAP_0 = (T_RP > T_RFC) ? T_RP : T_RFC;
  localparam int MAX_GAP_1 = (MAX_GAP_0 > T_MRD) ? MAX_GAP_0 : T_MRD;
  localparam int MAX_CNT   = (PAUSE_CYCLES > MAX_GAP_1) ? PAUSE_CYCLES : MAX_GAP_1;
  localparam int CNT_W     = $clog2(MAX_CNT + 1);

  localparam logic [CNT_W-1:0] LOAD_RP  = CNT_W'(T_RP - 2);
  localparam logic [CNT_W-1:0] LOAD_RFC = CNT_W'(T_RFC - 2);
  localparam logic [CNT_W-1:0] LOAD_MRD = CNT_W'(T_MRD - 2);

  init_state_e      state_q, state_d;
  logic             gap_zero;
  logic             gap_load;
  logic [CNT_W-1:0] gap_val;
  logic             ref_inc;
  logic             ref_all;
  cmd_pins_t        pins;

  sdram_init_timer #(
    .CNT_W     (CNT_W),
    .RESET_VAL (PAUSE_CYCLES - 1)
  ) i_gap_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (gap_load),
    .load_val_i (gap_val),
    .zero_o     (gap_zero)
  );

  sdram_init_ref_cnt #(
    .REFRESH_COUNT (REFRESH_COUNT)
  ) i_ref_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .inc_i      (ref_inc),
    .all_done_o (ref_all)
  );

  always_comb begin
    state_d  = state_q;
    gap_load = 1'b0;
    gap_val  = '0;
    ref_inc  = 1'b0;
    case (state_q)
      ST_PAUSE:    if (gap_zero) state_d = ST_PRECHG;
      ST_PRECHG: begin
        gap_load = 1'b1;
        gap_val  = LOAD_RP;
        state_d  = ST_WAIT_RP;
      end
      ST_WAIT_RP:  if (gap_zero) state_d = REFRESH_FIRST ? ST_REFRESH : ST_MODESET;
      ST_REFRESH: begin
        gap_load = 1'b1;
        gap_val  = LOAD_RFC;
        ref_inc  = 1'b1;
        state_d  = ST_WAIT_RFC;
      end
      ST_WAIT_RFC: begin
        if (gap_zero) begin
          if (!ref_all)          state_d = ST_REFRESH;
          else if (REFRESH_FIRST) state_d = ST_MODESET;
          else                   state_d = ST_IDLE;
        end
      end
      ST_MODESET: begin
        gap_load = 1'b1;
        gap_val  = LOAD_MRD;
        state_d  = ST_WAIT_MRD;
      end
      ST_WAIT_MRD: if (gap_zero) state_d = REFRESH_FIRST ? ST_IDLE : ST_REFRESH;
      default:     state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_PAUSE;
    else         state_q <= state_d;
  end

  sdram_init_cmd_enc #(
    .ADDR_W (ADDR_W),
    .AP_BIT (AP_BIT)
  ) i_cmd_enc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .cmd_i  (state_cmd(state_d)),
    .done_i (state_d == ST_IDLE),
    .mode_i (mode_i),
    .pins_o (pins),
    .addr_o (addr_o),
    .cke_o  (cke_o),
    .dqm_o  (dqm_o),
    .done_o (init_done_o)
  );

  assign cs_no  = pins.cs_n;
  assign ras_no = pins.ras_n;
  assign cas_no = pins.cas_n;
  assign we_no  = pins.we_n;

  // Checker-only count of cycles since reset release, saturating at the pause length
  logic [CNT_W-1:0] since_rst_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                  since_rst_q <= '0;
    else if (since_rst_q != CNT_W'(PAUSE_CYCLES)) since_rst_q <= since_rst_q + 1'b1;
  end

  a_r2_pause_nop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (since_rst_q < CNT_W'(PAUSE_CYCLES)) |->
      (pins == PINS_NOP && cke_o && dqm_o && addr_o == '0));

  a_r2_mask_until_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !init_done_o |-> (cke_o && dqm_o));

  a_r6_nop_after_mrs: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pins == PINS_MODESET) |=> (pins == PINS_NOP));

  a_r4_mrs_addr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pins == PINS_MODESET) |-> (addr_o == $past(mode_i)));

  a_r8_done_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    init_done_o |=> init_done_o);

  a_r9_idle_nop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    init_done_o |-> (pins == PINS_NOP && addr_o == '0 && !dqm_o && cke_o));

endmodule

// File: tb/test_sdram_init_seq.sv
module test_sdram_init_seq;

  localparam int CLK_PERIOD = 10;
  localparam int AW     = 13;
  localparam int P      = 40;
  localparam int RP     = 3;
  localparam int RFC    = 7;
  localparam int MRD    = 2;
  localparam int NREF   = 8;
  localparam int C_NOP  = 0;
  localparam int C_PRE  = 1;
  localparam int C_REF  = 2;
  localparam int C_MRS  = 3;
  localparam int C_DONE = 4;

  logic clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  logic          rst_n = 1'b0;
  logic [AW-1:0] mode_a = 13'h0033;
  logic [AW-1:0] mode_b = 13'h0227;

  logic a_cke, a_dqm, a_cs, a_ras, a_cas, a_we, a_done;
  logic b_cke, b_dqm, b_cs, b_ras, b_cas, b_we, b_done;
  logic [AW-1:0] a_addr, b_addr;

  int checks = 0;
  int failures = 0;
  int exp_a[$];
  int exp_b[$];
  bit seen_a, seen_b;

  sdram_init_seq #(
    .ADDR_W(AW), .AP_BIT(10), .PAUSE_CYCLES(P), .T_RP(RP), .T_RFC(RFC),
    .T_MRD(MRD), .REFRESH_COUNT(NREF), .REFRESH_FIRST(1'b0)
  ) i_sdram_init_seq (
    .clk_i(clk), .rst_ni(rst_n), .mode_i(mode_a), .cke_o(a_cke), .dqm_o(a_dqm),
    .cs_no(a_cs), .ras_no(a_ras), .cas_no(a_cas), .we_no(a_we),
    .addr_o(a_addr), .init_done_o(a_done)
  );

  sdram_init_seq #(
    .ADDR_W(AW), .AP_BIT(10), .PAUSE_CYCLES(P), .T_RP(RP), .T_RFC(RFC),
    .T_MRD(MRD), .REFRESH_COUNT(NREF), .REFRESH_FIRST(1'b1)
  ) i_sdram_init_seq_rf (
    .clk_i(clk), .rst_ni(rst_n), .mode_i(mode_b), .cke_o(b_cke), .dqm_o(b_dqm),
    .cs_no(b_cs), .ras_no(b_ras), .cas_no(b_cas), .we_no(b_we),
    .addr_o(b_addr), .init_done_o(b_done)
  );

  // Expected command per cycle, starting with the first edge after release
  function automatic void build(ref int q[$], input bit ref_first);
    q.delete();
    repeat (P - 1) q.push_back(C_NOP);
    q.push_back(C_PRE);
    repeat (RP - 1) q.push_back(C_NOP);
    if (!ref_first) begin
      q.push_back(C_MRS);
      repeat (MRD - 1) q.push_back(C_NOP);
    end
    repeat (NREF) begin
      q.push_back(C_REF);
      repeat (RFC - 1) q.push_back(C_NOP);
    end
    if (ref_first) begin
      q.push_back(C_MRS);
      repeat (MRD - 1) q.push_back(C_NOP);
    end
  endfunction

  function automatic string tag_of(int code, bit first_done);
    case (code)
      C_PRE:   return "R3";
      C_REF:   return "R5";
      C_MRS:   return "R4";
      C_DONE:  return first_done ? "R8" : "R9";
      default: return "R2/R6";
    endcase
  endfunction

  task automatic check_one(string who, string tag, int code,
                           logic cs, logic ras, logic cas, logic we,
                           logic cke, logic dqm, logic done,
                           logic [AW-1:0] addr, logic [AW-1:0] mode);
    logic [3:0]    got;
    logic [3:0]    exp_cmd;
    logic [AW-1:0] exp_addr;
    logic          exp_done;
    got = {cs, ras, cas, we};
    case (code)
      C_PRE:   begin exp_cmd = 4'b0010; exp_addr = AW'(1) << 10; end
      C_REF:   begin exp_cmd = 4'b0001; exp_addr = '0;           end
      C_MRS:   begin exp_cmd = 4'b0000; exp_addr = mode;         end
      default: begin exp_cmd = 4'b0111; exp_addr = '0;           end
    endcase
    exp_done = (code == C_DONE);
    checks++;
    if (got !== exp_cmd || addr !== exp_addr || cke !== 1'b1 ||
        dqm !== !exp_done || done !== exp_done) begin
      failures++;
      $display("FAIL %s %s t=%0t: got cmd=%b addr=%h cke=%b dqm=%b done=%b exp cmd=%b addr=%h cke=1 dqm=%b done=%b",
               tag, who, $time, got, addr, cke, dqm, done,
               exp_cmd, exp_addr, !exp_done, exp_done);
    end
  endtask

  task automatic step(string extra);
    int  ca, cb;
    bit  fa, fb;
    @(negedge clk);
    ca = (exp_a.size() == 0) ? C_DONE : exp_a.pop_front();
    cb = (exp_b.size() == 0) ? C_DONE : exp_b.pop_front();
    fa = (ca == C_DONE) && !seen_a;
    fb = (cb == C_DONE) && !seen_b;
    if (ca == C_DONE) seen_a = 1'b1;
    if (cb == C_DONE) seen_b = 1'b1;
    check_one("mrs-first", {tag_of(ca, fa), " ", extra}, ca,
              a_cs, a_ras, a_cas, a_we, a_cke, a_dqm, a_done, a_addr, mode_a);
    check_one("ref-first", {tag_of(cb, fb), " R7 ", extra}, cb,
              b_cs, b_ras, b_cas, b_we, b_cke, b_dqm, b_done, b_addr, mode_b);
  endtask

  // R1: reset state, then release on a falling edge
  task automatic reset_and_release(string extra);
    rst_n = 1'b0;
    repeat (3) begin
      @(negedge clk);
      check_one("mrs-first", {"R1 ", extra}, C_NOP,
                a_cs, a_ras, a_cas, a_we, a_cke, a_dqm, a_done, a_addr, mode_a);
      check_one("ref-first", {"R1 ", extra}, C_NOP,
                b_cs, b_ras, b_cas, b_we, b_cke, b_dqm, b_done, b_addr, mode_b);
    end
    build(exp_a, 1'b0);
    build(exp_b, 1'b1);
    seen_a = 1'b0;
    seen_b = 1'b0;
    rst_n  = 1'b1;
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    failures++;
    $display("FAIL watchdog: run did not complete (all requirements)");
    finish_run();
  end

  initial begin
    @(negedge clk);
    reset_and_release("");
    repeat (P + RP + MRD + NREF * RFC + 20) step("");

    mode_a = 13'h1020;
    mode_b = 13'h0aaa;
    reset_and_release("");
    repeat (P + 12) step("R10");          // stop part-way into the sequence
    reset_and_release("R10");
    repeat (P + RP + MRD + NREF * RFC + 20) step("R10");
    finish_run();
  end

endmodule